// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures how often an asynchronous input signal rises. A timer divides the reference clock into gate windows of a fixed, parameter-set number of reference cycles. During each window an event counter adds up the rising edges of the input. The input edges are first brought into the reference domain by a synchronizer and then reduced to one-cycle pulses by an edge detector.

When a window closes, the block copies the accumulated count into an output register, raises a one-cycle valid strobe and restarts the event counter from zero, all in one clock edge. Two window lengths are available. The long window is a parameter multiple (ten by default) of the short one, which trades update rate for resolution. The select input only takes effect where one window ends and the next begins.

If more edges arrive than the counter can hold, it stops at its largest value. An overflow flag is then reported with that result.

Top module: `freq_meter`

## Requirements
- R1: While `rst` is high, and until the first result is published, `count_out` is 0 and `ovf_out` and `count_valid` are low. The first window after reset is always a short one.
- R2: Every low-to-high transition of `sig_in` is counted exactly once, provided each level is held for at least one reference cycle. A level that is held steady adds nothing to the count.
- R3: A short window lasts `SHORT_DIV` reference cycles. A long window lasts `SHORT_DIV*LONG_RATIO` cycles. `gate_sel`=0 selects short and `gate_sel`=1 selects long.
- R4: `gate_sel` is sampled only on the clock edge that closes a window, and sets the length of the next window. A change in the middle of a window does not alter the current window.
- R5: On the closing edge, the window's count is copied to `count_out` and the event counter starts the next window from zero. Each result therefore holds exactly the edges detected in its own window.
- R6: An edge pulse that is detected on the same clock edge as the latch is credited to the new window and not to the finished one.
- R7: The event counter saturates at 2^`CNT_W`-1 instead of wrapping. If an edge arrives at saturation, `ovf_out` is set high along with that result, and the flag is cleared for the next window.
- R8: `count_valid` is high for exactly one cycle per published result. The rising edges of consecutive strobes are separated by exactly the length of the window just finished.
- R9: `count_out` and `ovf_out` change only in the cycle in which `count_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| gate_sel | input | 1 | Window length for the next window: 0 short, 1 long |
| count_out | output | CNT_W | Edge count of the last finished window |
| ovf_out | output | 1 | Last published count saturated |
| count_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench drives a fast toggle, so edge pulses regularly land on the latch edge. A design that credits such an edge to the old window produces results that are off by one in both adjacent windows. It flips `gate_sel` in the middle of windows. A design that reloads the length at once produces a strobe spacing that matches neither allowed length. Long windows with fast input drive a narrow counter to saturation. A counter that wraps reports a small count with no overflow flag. Steady high and low stretches catch a level-sensitive counter, which would count every cycle.

// File: rtl/freqcnt_pkg.sv
package freqcnt_pkg;

  typedef enum logic {
    GATE_SHORT = 1'b0,
    GATE_LONG  = 1'b1
  } gate_len_e;

  // Window length in reference cycles for a given selection
  function automatic int unsigned win_cycles(input gate_len_e sel,
                                             input int unsigned short_div,
                                             input int unsigned ratio);
    return (sel == GATE_LONG) ? short_div * ratio : short_div;
  endfunction

endpackage

// File: rtl/fc_sync_edge.sv
module fc_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign rise_pulse = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/fc_gate_timer.sv
module fc_gate_timer
  import freqcnt_pkg::*;
#(
  parameter int unsigned SHORT_DIV  = 10_000_000,
  parameter int unsigned LONG_RATIO = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_sel,
  output logic win_end
);

  localparam int unsigned LONG_DIV = SHORT_DIV * LONG_RATIO;
  localparam int unsigned TW       = (LONG_DIV > 2) ? $clog2(LONG_DIV) : 1;
  localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_DIV - 1);
  localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_DIV - 1);

  logic [TW-1:0] tick_q;
  logic [TW-1:0] last_q;
  gate_len_e     next_len;

  assign next_len = gate_len_e'(gate_sel);
  assign win_end  = (tick_q == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      last_q <= SHORT_LAST;
    end else if (win_end) begin
      tick_q <= '0;
      last_q <= (next_len == GATE_LONG) ? LONG_LAST : SHORT_LAST;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

endmodule

// File: rtl/fc_event_acc.sv
module fc_event_acc #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_pulse,
  input  logic             win_end,
  output logic [CNT_W-1:0] count_out,
  output logic             ovf_out,
  output logic             count_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] acc_q;
  logic             acc_ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      acc_ovf_q <= 1'b0;
    end else if (win_end) begin
      acc_q     <= {{(CNT_W-1){1'b0}}, ev_pulse};
      acc_ovf_q <= 1'b0;
    end else if (ev_pulse) begin
      if (acc_q == CNT_MAX) acc_ovf_q <= 1'b1;
      else                  acc_q     <= acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_out   <= '0;
      ovf_out     <= 1'b0;
      count_valid <= 1'b0;
    end else begin
      count_valid <= win_end;
      if (win_end) begin
        count_out <= acc_q;
        ovf_out   <= acc_ovf_q;
      end
    end
  end

endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SHORT_DIV   = 10_000_000,
  parameter int unsigned LONG_RATIO  = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic             gate_sel,
  output logic [CNT_W-1:0] count_out,
  output logic             ovf_out,
  output logic             count_valid
);

  logic ev_pulse;
  logic win_end;

  fc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst        (rst),
    .async_in   (sig_in),
    .rise_pulse (ev_pulse)
  );

  fc_gate_timer #(.SHORT_DIV(SHORT_DIV), .LONG_RATIO(LONG_RATIO)) gate_i (
    .clk      (clk),
    .rst      (rst),
    .gate_sel (gate_sel),
    .win_end  (win_end)
  );

  fc_event_acc #(.CNT_W(CNT_W)) acc_i (
    .clk         (clk),
    .rst         (rst),
    .ev_pulse    (ev_pulse),
    .win_end     (win_end),
    .count_out   (count_out),
    .ovf_out     (ovf_out),
    .count_valid (count_valid)
  );

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SHORT_DIV  = 10_000_000,
  parameter int unsigned LONG_RATIO = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_out,
  input logic             ovf_out,
  input logic             count_valid
);

  localparam int unsigned LONG_DIV = SHORT_DIV * LONG_RATIO;

  int unsigned since_q;

  always_ff @(posedge clk) begin
    if (rst)              since_q <= 0;
    else if (count_valid) since_q <= 1;
    else                  since_q <= since_q + 1;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    count_valid |=> !count_valid);  // R8

  AST_WINDOW_SPACING: assert property (@(posedge clk) disable iff (rst)
    count_valid |-> (since_q == SHORT_DIV || since_q == LONG_DIV));  // R3

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !count_valid |-> ($stable(count_out) && $stable(ovf_out)));  // R9

  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    ovf_out |-> (&count_out));  // R7

endmodule

bind freq_meter fc_checker #(
  .CNT_W(CNT_W), .SHORT_DIV(SHORT_DIV), .LONG_RATIO(LONG_RATIO)
) chk_i (
  .clk(clk), .rst(rst), .count_out(count_out),
  .ovf_out(ovf_out), .count_valid(count_valid)
);

// File: tb/freq_meter_tb_top.sv
module freq_meter_tb_top;

  localparam int unsigned W     = 5;
  localparam int unsigned SHORT = 40;
  localparam int unsigned RATIO = 10;
  localparam int unsigned LONG  = SHORT * RATIO;
  localparam int unsigned MAXV  = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sig_drv = 1'b0;
  logic         sel_drv = 1'b0;
  logic [W-1:0] count_out;
  logic         ovf_out;
  logic         count_valid;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  freq_meter #(.CNT_W(W), .SHORT_DIV(SHORT), .LONG_RATIO(RATIO)) dut_i (
    .clk(clk), .rst(rst), .sig_in(sig_drv), .gate_sel(sel_drv),
    .count_out(count_out), .ovf_out(ovf_out), .count_valid(count_valid)
  );

  function automatic int unsigned len_of(input logic s);
    return s ? LONG : SHORT;
  endfunction

  function automatic int unsigned sat_add(input int unsigned v);
    return (v == MAXV) ? v : v + 1;
  endfunction

  // Reference model from the requirements
  logic [2:0]  hist;
  int unsigned m_tick, m_len, m_acc;
  logic        m_ovf;
  int unsigned exp_cnt[$];
  int unsigned exp_len[$];
  logic        exp_ovf[$];
  int          coincide = 0;
  int          midwin = 0;
  logic        rst_seen = 1'b1;

  always @(posedge clk) begin
    logic pulse;
    rst_seen <= rst;
    if (rst) begin
      hist <= '0; m_tick <= 0; m_len <= SHORT; m_acc <= 0; m_ovf <= 1'b0;
    end else begin
      pulse = hist[1] & ~hist[2];
      hist <= {hist[1:0], sig_drv};
      if (m_tick == m_len - 1) begin
        exp_cnt.push_back(m_acc);
        exp_ovf.push_back(m_ovf);
        exp_len.push_back(m_len);
        if (pulse) coincide++;           // R6: credited to the new window
        m_acc  <= pulse ? 1 : 0;
        m_ovf  <= 1'b0;
        m_tick <= 0;
        m_len  <= len_of(sel_drv);       // R4: sampled only here
      end else begin
        m_tick <= m_tick + 1;
        if (pulse) begin
          if (m_acc == MAXV) m_ovf <= 1'b1;
          m_acc <= sat_add(m_acc);
        end
      end
    end
  end

  // Output checks, away from the active edge
  int unsigned gap = 0;
  logic [W-1:0] last_cnt = '0;
  logic         last_ovf = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      compared++;
      if (count_out !== '0 || ovf_out !== 1'b0 || count_valid !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 reset state: got cnt=%0d ovf=%0b vld=%0b exp 0/0/0",
                 count_out, ovf_out, count_valid);
      end
      gap = 0;
    end else if (!rst_seen) begin
      gap++;
      if (count_valid) begin
        compared++;
        if (exp_cnt.size() == 0) begin
          mismatched++;
          $display("FAIL R8 unexpected strobe: got vld=1 exp vld=0");
        end else begin
          int unsigned ec, el;
          logic eo;
          ec = exp_cnt.pop_front(); el = exp_len.pop_front(); eo = exp_ovf.pop_front();
          if (gap != el) begin
            mismatched++;
            $display("FAIL R3/R4 window length: got %0d exp %0d", gap, el);
          end
          compared++;
          if (count_out !== W'(ec)) begin
            mismatched++;
            $display("FAIL R2/R5/R6 count: got %0d exp %0d", count_out, ec);
          end
          compared++;
          if (ovf_out !== eo) begin
            mismatched++;
            $display("FAIL R7 overflow flag: got %0b exp %0b", ovf_out, eo);
          end
        end
        gap = 0;
        last_cnt = count_out;
        last_ovf = ovf_out;
      end else begin
        compared++;
        if (count_out !== last_cnt || ovf_out !== last_ovf) begin
          mismatched++;
          $display("FAIL R9 output changed without strobe: got %0d/%0b exp %0d/%0b",
                   count_out, ovf_out, last_cnt, last_ovf);
        end
      end
    end
  end

  // Stimulus helpers: drive away from both clock edges
  task automatic step();
    @(posedge clk); #3;
  endtask

  // Square-ish wave with given high/low lengths; sel flips at random points
  task automatic wave(input int hi, input int lo, input int cycles, input bit flip_sel);
    int ph = 0;
    for (int c = 0; c < cycles; c++) begin
      step();
      sig_drv = (ph < hi);
      ph = (ph + 1 == hi + lo) ? 0 : ph + 1;
      if (flip_sel && ($urandom % 97 == 0)) begin
        sel_drv = ~sel_drv;
        if (m_tick != 0) midwin++;
      end
    end
  endtask

  task automatic level(input logic v, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      step();
      sig_drv = v;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0F1C));
    rst = 1'b1;
    repeat (5) step();
    rst = 1'b0;

    // R1: first window short even with long selected from the start
    sel_drv = 1'b1;
    wave(3, 4, 40, 1'b0);
    sel_drv = 1'b0;
    // R2: steady levels count nothing beyond the one rise
    level(1'b1, 130);
    level(1'b0, 90);
    // R6: fastest toggle, pulses fall on latch edges
    wave(1, 1, 400, 1'b0);
    // R7: long windows with fast input saturate the counter
    sel_drv = 1'b1;
    wave(1, 1, 1300, 1'b0);
    // Long windows, slow input, no saturation
    wave(7, 9, 900, 1'b0);
    // Random mix with mid-window select flips (R4)
    for (int p = 0; p < 24; p++) begin
      int hi, lo;
      hi = 1 + int'($urandom % 12);
      lo = 1 + int'($urandom % 12);
      wave(hi, lo, 200 + int'($urandom % 500), 1'b1);
    end
    // Drain: finish the window in progress
    sel_drv = 1'b0;
    level(1'b0, LONG + SHORT + 4);

    compared++;
    if (coincide == 0) begin
      mismatched++;
      $display("FAIL R6 coverage: got %0d latch-edge pulses exp >0", coincide);
    end
    compared++;
    if (midwin == 0) begin
      mismatched++;
      $display("FAIL R4 coverage: got %0d mid-window flips exp >0", midwin);
    end
    compared++;
    if (exp_cnt.size() != 0) begin
      mismatched++;
      $display("FAIL R8 missing strobes: got %0d pending exp 0", exp_cnt.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule